// File: doc/BRIEF.md
# SIMD Pixel Processor Array

A small two-dimensional mesh of identical processing elements, one per pixel, all driven by one broadcast instruction word in lockstep. Every element keeps six general registers, a pixel register, an exchange register, a scale register and an enable flag. Because every element runs the same instruction, each register acts as an image-sized plane, and one instruction moves or combines whole planes.

One instruction adds any chosen subset of the general, pixel and exchange registers into a destination, with each operand optionally negated, and completes in a single clock. Scaling runs only through the scale register. The flag is set from a sign test and gates every register write. Data moves between elements only through the exchange register, one step to a chosen neighbour. A pixel frame arrives on a parallel bus. The readout port returns one element's value, or the sum over a row, a column or the whole array. That global sum supports operations such as histograms.

Top module: `simd_pixel_array`

## Requirements
- R1: After reset every register of every element reads 0, every flag is 1, and every readout returns 0.
- R2: Opcode 0 (sum) writes to the destination the sum of every source whose bit is set in `instr_src_en`, each negated when its bit in `instr_src_neg` is set. The destination is visible on the next clock. Source bits: 0..5 are general registers A..F, 6 is the pixel register, 7 is the exchange register. Destination codes: 0..5 are A..F, 6 is the exchange register, 7 is the scale register.
- R3: Results are 12-bit two's complement and clamp to the range -2048..2047 instead of wrapping.
- R4: Opcode 1 (scale) writes floor(S*M/256), clamped as in R3. S is the operand sum defined in R2 and M is the element's own scale register.
- R5: An element with its flag clear does not change any register on sum, scale, neighbour-load or pixel-load.
- R6: Opcode 2 sets each flag to 1 when the element's operand sum is >= 0 and to 0 otherwise, and opcode 3 sets every flag. Both run whatever the current flag is.
- R7: Opcode 4 loads each exchange register from the exchange register of the neighbour selected by `instr_dir`: 0 = row-1, 1 = col+1, 2 = row+1, 3 = col-1. Where that neighbour would lie outside the array, the value loaded is 0.
- R8: Opcode 5 loads the pixel register of the element at (r,c) from `pix_in[(r*COLS+c)*12 +: 12]`. Reading the pixel register, as an operand or at the readout, leaves it unchanged.
- R9: The readout returns the register chosen by `rd_sel` (source code as in R2), taken from the current state. `rd_mode` selects the scope: 0 = the element at (`rd_row`,`rd_col`), 1 = the sum over row `rd_row`, 2 = the sum over column `rd_col`, 3 = the sum over all elements.
- R10: While `instr_valid` is low, no register or flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr_op | input | 3 | Opcode |
| instr_dst | input | 3 | Destination register code |
| instr_src_en | input | 8 | Operand enable mask |
| instr_src_neg | input | 8 | Operand negate mask |
| instr_dir | input | 2 | Neighbour direction |
| pix_in | input | ROWS*COLS*12 | Pixel frame |
| rd_mode | input | 2 | Readout scope |
| rd_row | input | 2 | Readout row |
| rd_col | input | 2 | Readout column |
| rd_sel | input | 3 | Readout register code |
| rd_data | output | 17 | Readout value or sum |

## Verification
The bench drives sums of three full-scale operands in both signs and negates the most negative value. A wrapping adder would report a result of the wrong sign. Scaling uses a negative odd pixel, where truncation toward zero gives a value one higher than the expected floor. The bench runs a comparison while some flags are already clear, so a design that gated flag updates would leave those elements stuck. Neighbour loads in all four directions check the zero fill at every edge, which catches swapped directions and wrapped indices.

// File: rtl/simd_pixel_array.sv
module simd_pixel_array #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int W    = 12,
  parameter int NG   = 6,
  parameter int FRAC = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                instr_valid,
  input  logic [2:0]                          instr_op,
  input  logic [$clog2(NG+2)-1:0]             instr_dst,
  input  logic [NG+1:0]                       instr_src_en,
  input  logic [NG+1:0]                       instr_src_neg,
  input  logic [1:0]                          instr_dir,
  input  logic [ROWS*COLS*W-1:0]              pix_in,
  input  logic [1:0]                          rd_mode,
  input  logic [$clog2(ROWS)-1:0]             rd_row,
  input  logic [$clog2(COLS)-1:0]             rd_col,
  input  logic [$clog2(NG+2)-1:0]             rd_sel,
  output logic signed [W+$clog2(ROWS*COLS):0] rd_data
);
  localparam int NE   = ROWS * COLS;
  localparam int NSRC = NG + 2;
  localparam int DSTW = $clog2(NG + 2);
  localparam int SUMW = W + $clog2(NSRC) + 1;
  localparam int PRW  = SUMW + W;
  localparam int RDW  = W + $clog2(NE) + 1;
  localparam logic [2:0] OP_SUM = 3'd0, OP_SCALE = 3'd1, OP_CMP = 3'd2,
                         OP_SETALL = 3'd3, OP_NBR = 3'd4, OP_PIX = 3'd5;
  localparam logic [DSTW-1:0] D_XCH = DSTW'(NG);
  localparam logic [DSTW-1:0] D_SCL = DSTW'(NG + 1);
  localparam logic signed [PRW-1:0] SAT_MAX = (PRW'(1) <<< (W - 1)) - PRW'(1);
  localparam logic signed [PRW-1:0] SAT_MIN = -SAT_MAX - PRW'(1);

  function automatic logic signed [W-1:0] clamp(input logic signed [PRW-1:0] v);
    if (v > SAT_MAX) return SAT_MAX[W-1:0];
    else if (v < SAT_MIN) return SAT_MIN[W-1:0];
    else return v[W-1:0];
  endfunction

  logic signed [W-1:0]    gr     [NE][NG];
  logic signed [W-1:0]    pix_r  [NE];
  logic signed [W-1:0]    xch_r  [NE];
  logic signed [W-1:0]    scl_r  [NE];
  logic [NE-1:0]          flag_r;
  logic signed [W-1:0]    sv     [NE][NSRC];
  logic signed [SUMW-1:0] acc    [NE];
  logic signed [W-1:0]    res    [NE];
  logic signed [W-1:0]    nb     [NE];
  logic signed [RDW-1:0]  rd_acc;

  always_comb begin
    for (int e = 0; e < NE; e++) begin
      for (int g = 0; g < NG; g++) sv[e][g] = gr[e][g];
      sv[e][NG]   = pix_r[e];
      sv[e][NG+1] = xch_r[e];
    end
  end

  always_comb begin
    logic signed [SUMW-1:0] term;
    logic signed [PRW-1:0]  prod;
    for (int e = 0; e < NE; e++) begin
      acc[e] = '0;
      for (int s = 0; s < NSRC; s++) begin
        term = SUMW'(sv[e][s]);
        if (instr_src_en[s]) acc[e] = instr_src_neg[s] ? acc[e] - term : acc[e] + term;
      end
      prod   = PRW'(acc[e]) * PRW'(scl_r[e]);
      res[e] = (instr_op == OP_SCALE) ? clamp(prod >>> FRAC) : clamp(PRW'(acc[e]));
    end
  end

  for (genvar e = 0; e < NE; e++) begin : g_nb
    localparam int R = e / COLS;
    localparam int C = e % COLS;
    logic signed [W-1:0] up, rt, dn, lf;
    if (R > 0) begin : g_up
      assign up = xch_r[e-COLS];
    end else begin : g_up0
      assign up = '0;
    end
    if (C < COLS - 1) begin : g_rt
      assign rt = xch_r[e+1];
    end else begin : g_rt0
      assign rt = '0;
    end
    if (R < ROWS - 1) begin : g_dn
      assign dn = xch_r[e+COLS];
    end else begin : g_dn0
      assign dn = '0;
    end
    if (C > 0) begin : g_lf
      assign lf = xch_r[e-1];
    end else begin : g_lf0
      assign lf = '0;
    end
    assign nb[e] = (instr_dir == 2'd0) ? up : (instr_dir == 2'd1) ? rt :
                   (instr_dir == 2'd2) ? dn : lf;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NE; e++) begin
        for (int g = 0; g < NG; g++) gr[e][g] <= '0;
        pix_r[e] <= '0;
        xch_r[e] <= '0;
        scl_r[e] <= '0;
      end
      flag_r <= '1;
    end else if (instr_valid) begin
      for (int e = 0; e < NE; e++) begin
        case (instr_op)
          OP_SUM, OP_SCALE:
            if (flag_r[e]) begin
              if (instr_dst < D_XCH) gr[e][instr_dst] <= res[e];
              else if (instr_dst == D_XCH) xch_r[e] <= res[e];
              else if (instr_dst == D_SCL) scl_r[e] <= res[e];
            end
          OP_CMP:    flag_r[e] <= ~acc[e][SUMW-1];
          OP_SETALL: flag_r[e] <= 1'b1;
          OP_NBR:    if (flag_r[e]) xch_r[e] <= nb[e];
          OP_PIX:    if (flag_r[e]) pix_r[e] <= pix_in[e*W +: W];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_acc = '0;
    for (int e = 0; e < NE; e++) begin
      if (rd_mode == 2'd3 ||
          (rd_mode == 2'd1 && e / COLS == int'(rd_row)) ||
          (rd_mode == 2'd2 && e % COLS == int'(rd_col)) ||
          (rd_mode == 2'd0 && e / COLS == int'(rd_row) && e % COLS == int'(rd_col)))
        rd_acc = rd_acc + RDW'(sv[e][rd_sel]);
    end
  end
  assign rd_data = rd_acc;

  assert_gated_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_op == OP_SUM && !flag_r[0]) |=>
      ($stable(gr[0][0]) && $stable(xch_r[0]) && $stable(scl_r[0])));
  assert_setall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_op == OP_SETALL) |=> (&flag_r));
  assert_cmp_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_op == OP_CMP) |=> (flag_r[0] == ~$past(acc[0][SUMW-1])));
  assert_edge_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_op == OP_NBR && instr_dir == 2'd0 && flag_r[0]) |=> (xch_r[0] == '0));
  assert_pix_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(instr_valid && instr_op == OP_PIX) |=> $stable(pix_r[0]));
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> ($stable(flag_r) && $stable(scl_r[0]) && $stable(gr[0][0])));
endmodule

// File: tb/test_simd_pixel_array.sv
`timescale 1ns/1ps
module test_simd_pixel_array;
  localparam logic [2:0] SUM = 0, SCALE = 1, CMP = 2, SETALL = 3, NBR = 4, PIXLD = 5;
  localparam logic [7:0] A = 8'h01, B = 8'h02, C = 8'h04, PX = 8'h40;

  logic clk = 0, rst_n = 0, instr_valid = 0;
  logic [2:0] instr_op = 0, instr_dst = 0, rd_sel = 0;
  logic [7:0] instr_src_en = 0, instr_src_neg = 0;
  logic [1:0] instr_dir = 0, rd_mode = 0, rd_row = 0, rd_col = 0;
  logic [16*12-1:0] pix_in = '0;
  logic signed [16:0] rd_data;
  int checks = 0, errors = 0;
  int expv [16];

  always #2.5 clk = ~clk;

  simd_pixel_array i_simd_pixel_array (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
    .instr_dst(instr_dst), .instr_src_en(instr_src_en), .instr_src_neg(instr_src_neg),
    .instr_dir(instr_dir), .pix_in(pix_in), .rd_mode(rd_mode), .rd_row(rd_row),
    .rd_col(rd_col), .rd_sel(rd_sel), .rd_data(rd_data));

  function automatic int pp(int e);
    return (e / 4) * 16 + (e % 4) * 3 - 10;
  endfunction

  task automatic check(int got, int exp, string req);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic rd(int mode, int row, int col, int sel, output int v);
    rd_mode = 2'(mode); rd_row = 2'(row); rd_col = 2'(col); rd_sel = 3'(sel);
    #1 v = int'(rd_data);
  endtask

  task automatic check_plane(int sel, string req);
    int v, s;
    for (int e = 0; e < 16; e++) begin
      rd(0, e / 4, e % 4, sel, v);
      check(v, expv[e], {req, " single R9"});
    end
    for (int r = 0; r < 4; r++) begin
      s = 0;
      for (int c = 0; c < 4; c++) s += expv[r*4+c];
      rd(1, r, 0, sel, v);
      check(v, s, {req, " row R9"});
    end
    for (int c = 0; c < 4; c++) begin
      s = 0;
      for (int r = 0; r < 4; r++) s += expv[r*4+c];
      rd(2, 0, c, sel, v);
      check(v, s, {req, " col R9"});
    end
    s = 0;
    for (int e = 0; e < 16; e++) s += expv[e];
    rd(3, 0, 0, sel, v);
    check(v, s, {req, " all R9"});
  endtask

  task automatic exec(logic [2:0] op, logic [2:0] dst, logic [7:0] en, logic [7:0] neg, logic [1:0] dir);
    @(negedge clk);
    instr_op = op; instr_dst = dst; instr_src_en = en; instr_src_neg = neg; instr_dir = dir;
    instr_valid = 1;
    @(negedge clk);
    instr_valid = 0;
  endtask

  task automatic pix_pattern();
    for (int e = 0; e < 16; e++) pix_in[e*12 +: 12] = 12'(pp(e));
  endtask

  task automatic pix_const(int v);
    for (int e = 0; e < 16; e++) pix_in[e*12 +: 12] = 12'(v);
  endtask

  task automatic t_reset();
    for (int e = 0; e < 16; e++) expv[e] = 0;
    for (int s = 0; s < 8; s++) check_plane(s, "R1");
  endtask

  task automatic t_pixel();
    pix_pattern();
    exec(PIXLD, 0, 0, 0, 0);
    for (int e = 0; e < 16; e++) expv[e] = pp(e);
    check_plane(6, "R8");
    pix_const(5);
    exec(SUM, 0, PX, 0, 0);
    check_plane(0, "R8 copy");
    check_plane(6, "R8 nondestructive");
  endtask

  task automatic t_sum();
    exec(SUM, 1, A | PX, PX, 0);
    for (int e = 0; e < 16; e++) expv[e] = 0;
    check_plane(1, "R2 cancel");
    exec(SUM, 2, A | PX, 0, 0);
    for (int e = 0; e < 16; e++) expv[e] = 2 * pp(e);
    check_plane(2, "R2 add");
    exec(SUM, 4, A | C, A, 0);
    for (int e = 0; e < 16; e++) expv[e] = pp(e);
    check_plane(4, "R2 negate");
  endtask

  task automatic t_sat();
    pix_const(2000);
    exec(PIXLD, 0, 0, 0, 0);
    exec(SUM, 0, PX, 0, 0);
    exec(SUM, 1, PX, 0, 0);
    exec(SUM, 2, A | B | PX, 0, 0);
    for (int e = 0; e < 16; e++) expv[e] = 2047;
    check_plane(2, "R3 high");
    exec(SUM, 2, A | B | PX, A | B | PX, 0);
    for (int e = 0; e < 16; e++) expv[e] = -2048;
    check_plane(2, "R3 low");
    pix_const(-2048);
    exec(PIXLD, 0, 0, 0, 0);
    exec(SUM, 4, PX, PX, 0);
    for (int e = 0; e < 16; e++) expv[e] = 2047;
    check_plane(4, "R3 negate min");
  endtask

  task automatic t_scale();
    pix_const(128);
    exec(PIXLD, 0, 0, 0, 0);
    exec(SUM, 7, PX, 0, 0);
    pix_pattern();
    exec(PIXLD, 0, 0, 0, 0);
    exec(SCALE, 0, PX, 0, 0);
    for (int e = 0; e < 16; e++) expv[e] = (pp(e) * 128) >>> 8;
    check_plane(0, "R4 half");
    pix_const(2000);
    exec(PIXLD, 0, 0, 0, 0);
    exec(SUM, 7, PX, 0, 0);
    exec(SCALE, 0, PX, 0, 0);
    for (int e = 0; e < 16; e++) expv[e] = 2047;
    check_plane(0, "R4 clamp high");
    pix_const(-2000);
    exec(PIXLD, 0, 0, 0, 0);
    exec(SCALE, 0, PX, 0, 0);
    for (int e = 0; e < 16; e++) expv[e] = -2048;
    check_plane(0, "R4 clamp low");
  endtask

  task automatic t_flag();
    pix_pattern();
    exec(PIXLD, 0, 0, 0, 0);
    exec(CMP, 0, PX, 0, 0);
    exec(SUM, 3, PX, 0, 0);
    for (int e = 0; e < 16; e++) expv[e] = (pp(e) >= 0) ? pp(e) : 0;
    check_plane(3, "R5 gated");
    exec(CMP, 0, PX, PX, 0);
    exec(SUM, 5, PX, 0, 0);
    for (int e = 0; e < 16; e++) expv[e] = (pp(e) <= 0) ? pp(e) : 0;
    check_plane(5, "R6 compare ungated");
    exec(SETALL, 0, 0, 0, 0);
    exec(SUM, 5, PX, 0, 0);
    for (int e = 0; e < 16; e++) expv[e] = pp(e);
    check_plane(5, "R6 set all");
  endtask

  task automatic t_nbr();
    for (int d = 0; d < 4; d++) begin
      exec(SUM, 6, PX, 0, 0);
      exec(NBR, 0, 0, 0, 2'(d));
      for (int e = 0; e < 16; e++) begin
        int r = e / 4, c = e % 4;
        case (d)
          0: expv[e] = (r > 0) ? pp(e - 4) : 0;
          1: expv[e] = (c < 3) ? pp(e + 1) : 0;
          2: expv[e] = (r < 3) ? pp(e + 4) : 0;
          default: expv[e] = (c > 0) ? pp(e - 1) : 0;
        endcase
      end
      check_plane(7, "R7 neighbour");
    end
  endtask

  task automatic t_idle();
    @(negedge clk);
    instr_op = SUM; instr_dst = 0; instr_src_en = PX; instr_src_neg = 0; instr_valid = 0;
    repeat (3) @(negedge clk);
    for (int e = 0; e < 16; e++) expv[e] = -2048;
    check_plane(0, "R10 idle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_pixel();
    t_sum();
    t_sat();
    t_scale();
    t_flag();
    t_nbr();
    t_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule